// File: doc/BRIEF.md
# SPI Receive/Transmit Data Buffer

This block is the data-register layer of an SPI peripheral. It sits between a byte-wide register bus and the shift engine. Software writes a 16-bit transmit word as two bytes. The engine takes that word when a transfer starts. When a transfer completes, the engine hands back the received word, which software reads as two bytes. Two flags show the state of the buffer: `tx_empty` means a new transmit word can be queued, and `rx_full` means the visible receive word is valid.

Behind the visible receive register there is one hidden holding slot. A word that completes while `rx_full` is still set is parked in that slot. If software services the flag before the next transfer starts, the parked word moves into the visible register and the flag stays set. If the next transfer starts first, the parked word is dropped and never becomes visible. Software services the flag in two steps: it reads the status byte while `rx_full` is set, and then it reads the low data byte. The shift engine drives the one-cycle strobes `xfer_start` and `xfer_done`.

Top module: `spi_dbuf`

## Requirements
- R1: After reset, `rx_full` is 0, `tx_empty` is 1, `tx_word` is 0, and both data bytes read as 0.
- R2: A bus write to offset 0x04 (high byte) only stages that byte. `tx_word` and `tx_empty` stay unchanged.
- R3: A bus write to offset 0x05 (low byte) sets `tx_word` to {staged high byte, written byte} and clears `tx_empty` on the next cycle.
- R4: `xfer_start` sets `tx_empty`. If a low-byte write falls in the same cycle, the new word is queued and `tx_empty` stays 0.
- R5: An `xfer_done` while `rx_full` is clear loads `rx_word` into the visible register and sets `rx_full`.
- R6: An `xfer_done` while `rx_full` is set leaves the visible register unchanged and parks `rx_word` in the holding slot.
- R7: Servicing the flag with no parked word clears `rx_full`. Servicing means reading offset 0x03 while `rx_full` is 1, and then reading offset 0x05.
- R8: Servicing the flag while a parked word is valid moves that word into the visible register and keeps `rx_full` at 1. A new status read is needed before the next service.
- R9: An `xfer_start` invalidates the parked word. A later service then clears `rx_full`, and the visible register keeps its old value.
- R10: If a service and `xfer_start` fall in the same cycle, the start wins. The parked word is dropped and `rx_full` clears.
- R11: If a service and `xfer_done` fall in the same cycle, the service is applied first and the completion second. The completion word goes to the visible register if the service cleared the flag, and to the holding slot otherwise.
- R12: Reads return bits 15:8 of the visible word at offset 0x04 and bits 7:0 at offset 0x05. At offset 0x03 they return the status byte: bit 7 is `rx_full`, bit 0 is `tx_empty`, and the other bits are 0. Any other offset reads 0.
- R13: A low-byte read that is not preceded by a status read while `rx_full` is 1 does not change `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (qualifies side effects of reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| xfer_start | input | 1 | Shift engine begins a transfer and takes `tx_word` |
| xfer_done | input | 1 | Shift engine finished a transfer, `rx_word` is valid |
| rx_word | input | 16 | Word received by the shift engine |
| tx_word | output | 16 | Queued transmit word |
| tx_empty | output | 1 | Transmit register can accept a new word |
| rx_full | output | 1 | Visible receive word is valid |

## Verification
The functions that can coincide are a software service of the receive flag and a shift-engine strobe in the same cycle. A start strobe in that cycle decides whether the parked word survives. A completion strobe in that cycle decides whether the new word lands in the visible register or in the holding slot. The bench provokes both by putting the low-byte read and the strobe into one bus cycle, once with a word parked and once without. It then judges the outcome from `rx_full` and from visible-word reads that do not themselves service the flag. On the transmit side, a low-byte write and a start in the same cycle must leave `tx_empty` clear.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'h3;
  localparam logic [ADDR_W-1:0] OFS_DHI  = 3'h4;
  localparam logic [ADDR_W-1:0] OFS_DLO  = 3'h5;
  localparam int ST_RXF_BIT = 7;
  localparam int ST_TXE_BIT = 0;
endpackage

// File: rtl/spi_dbuf_rst.sv
module spi_dbuf_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/spi_dbuf_tx.sv
module spi_dbuf_tx #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                xfer_start,
  output logic [2*BYTE_W-1:0] tx_word,
  output logic                tx_empty
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] stage_q, stage_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              empty_q, empty_d;

  always_comb begin
    stage_d = stage_q;
    word_d  = word_q;
    empty_d = empty_q;
    if (hi_wr) stage_d = wdata;
    if (xfer_start) empty_d = 1'b1;
    if (lo_wr) begin
      word_d  = {stage_q, wdata};
      empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      word_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      stage_q <= stage_d;
      word_q  <= word_d;
      empty_q <= empty_d;
    end
  end

  assign tx_word  = word_q;
  assign tx_empty = empty_q;
endmodule

// File: rtl/spi_dbuf_rx.sv
module spi_dbuf_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              lo_rd,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] vis_word,
  output logic              rx_full,
  output logic              hold_valid
);
  logic [WORD_W-1:0] vis_q, vis_d, hold_q, hold_d;
  logic              full_q, full_d, hv_q, hv_d, arm_q, arm_d;
  logic              service;

  assign service = lo_rd && arm_q;

  always_comb begin
    vis_d  = vis_q;
    hold_d = hold_q;
    full_d = full_q;
    hv_d   = hv_q;
    arm_d  = arm_q;
    if (stat_rd && full_q) arm_d = 1'b1;
    if (xfer_start) hv_d = 1'b0;
    if (service) begin
      arm_d = 1'b0;
      if (hv_d) begin
        vis_d = hold_q;
        hv_d  = 1'b0;
      end else begin
        full_d = 1'b0;
      end
    end
    if (xfer_done) begin
      if (full_d) begin
        hold_d = rx_word;
        hv_d   = 1'b1;
      end else begin
        vis_d  = rx_word;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q  <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      hv_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      vis_q  <= vis_d;
      hold_q <= hold_d;
      full_q <= full_d;
      hv_q   <= hv_d;
      arm_q  <= arm_d;
    end
  end

  assign vis_word   = vis_q;
  assign rx_full    = full_q;
  assign hold_valid = hv_q;
endmodule

// File: rtl/spi_dbuf.sv
module spi_dbuf
  import spi_dbuf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                xfer_start,
  input  logic                xfer_done,
  input  logic [2*BYTE_W-1:0] rx_word,
  output logic [2*BYTE_W-1:0] tx_word,
  output logic                tx_empty,
  output logic                rx_full
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              rst_sync_n;
  logic [WORD_W-1:0] rx_vis;
  logic              hold_valid;
  logic              hi_wr, lo_wr, stat_rd, lo_rd;

  assign hi_wr   = bus_wr && (bus_addr == OFS_DHI);
  assign lo_wr   = bus_wr && (bus_addr == OFS_DLO);
  assign stat_rd = bus_rd && (bus_addr == OFS_STAT);
  assign lo_rd   = bus_rd && (bus_addr == OFS_DLO);

  spi_dbuf_rst u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_dbuf_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hi_wr      (hi_wr),
    .lo_wr      (lo_wr),
    .wdata      (bus_wdata),
    .xfer_start (xfer_start),
    .tx_word    (tx_word),
    .tx_empty   (tx_empty)
  );

  spi_dbuf_rx #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stat_rd    (stat_rd),
    .lo_rd      (lo_rd),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .rx_word    (rx_word),
    .vis_word   (rx_vis),
    .rx_full    (rx_full),
    .hold_valid (hold_valid)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STAT: begin
        bus_rdata[ST_RXF_BIT] = rx_full;
        bus_rdata[ST_TXE_BIT] = tx_empty;
      end
      OFS_DHI: bus_rdata = rx_vis[WORD_W-1:BYTE_W];
      OFS_DLO: bus_rdata = rx_vis[BYTE_W-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk
  import spi_dbuf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic                xfer_start,
  input logic                xfer_done,
  input logic [2*BYTE_W-1:0] tx_word,
  input logic                tx_empty,
  input logic                rx_full,
  input logic [2*BYTE_W-1:0] rx_vis
);
  a_r2_hi_keeps_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr != OFS_DLO) |=> $stable(tx_word));

  a_r3_commit_clears_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_DLO) |=> !tx_empty);

  a_r4_start_sets_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_start && !(bus_wr && bus_addr == OFS_DLO)) |=> tx_empty);

  a_r5_done_sets_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_done |=> rx_full);

  a_r6_full_keeps_visible: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_full && !(bus_rd && bus_addr == OFS_DLO)) |=> $stable(rx_vis));

  a_r13_no_clear_without_lo_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_full && !(bus_rd && bus_addr == OFS_DLO)) |=> rx_full);
endmodule

bind spi_dbuf spi_dbuf_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .xfer_start (xfer_start),
  .xfer_done  (xfer_done),
  .tx_word    (tx_word),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .rx_vis     (rx_vis)
);

// File: tb/spi_dbuf_test.sv
`timescale 1ns/1ps
module spi_dbuf_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        xfer_start, xfer_done;
  logic [15:0] rx_word, tx_word;
  logic        tx_empty, rx_full;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spi_dbuf uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .rx_word(rx_word),
    .tx_word(tx_word), .tx_empty(tx_empty), .rx_full(rx_full)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic [2:0] a, input logic [7:0] d,
                     input logic st, input logic dn, input logic [15:0] w, output logic [7:0] r);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    xfer_start = st; xfer_done = dn; rx_word = w;
    #1 r = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; xfer_start = 1'b0; xfer_done = 1'b0;
  endtask

  logic [7:0] rb;

  task automatic idle();    cyc(0, 0, 3'h0, 8'h00, 0, 0, 16'h0, rb); endtask
  task automatic wr_b(input logic [2:0] a, input logic [7:0] d); cyc(0, 1, a, d, 0, 0, 16'h0, rb); endtask
  task automatic rd_b(input logic [2:0] a, output logic [7:0] r); cyc(1, 0, a, 8'h00, 0, 0, 16'h0, r); endtask
  task automatic done_w(input logic [15:0] w); cyc(0, 0, 3'h0, 8'h00, 0, 1, w, rb); endtask
  task automatic start_x(); cyc(0, 0, 3'h0, 8'h00, 1, 0, 16'h0, rb); endtask

  // peek reads high then low without a preceding status read
  task automatic peek(output logic [15:0] v);
    logic [7:0] h, l;
    rd_b(3'h4, h);
    rd_b(3'h5, l);
    v = {h, l};
  endtask

  task automatic service();
    logic [7:0] s;
    rd_b(3'h3, s);
    rd_b(3'h5, s);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, prev;
    logic [7:0]  s;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    xfer_start = 0; xfer_done = 0; rx_word = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();

    // R1 reset state
    chk(!rx_full, "R1 rx_full", {15'd0, rx_full}, 16'd0);
    chk(tx_empty, "R1 tx_empty", {15'd0, tx_empty}, 16'd1);
    chk(tx_word == 16'h0, "R1 tx_word", tx_word, 16'h0);
    peek(v);
    chk(v == 16'h0, "R1 data read", v, 16'h0);
    rd_b(3'h3, s);
    chk(s == 8'h01, "R12 status byte", {8'h0, s}, 16'h0001);
    rd_b(3'h6, s);
    chk(s == 8'h00, "R12 unused offset", {8'h0, s}, 16'h0);

    // transmit sweep
    prev = 16'h0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] hb, lb;
      hb = 8'((k * 37 + 5) & 8'hFF);
      lb = 8'((k * 91 + 3) & 8'hFF);
      wr_b(3'h4, hb);
      chk(tx_word == prev, "R2 hi write keeps word", tx_word, prev);
      chk(tx_empty, "R2 hi write keeps empty", {15'd0, tx_empty}, 16'd1);
      if (k % 2 == 0) begin
        wr_b(3'h5, lb);
        chk(tx_word == {hb, lb}, "R3 commit word", tx_word, {hb, lb});
        chk(!tx_empty, "R3 commit clears empty", {15'd0, tx_empty}, 16'd0);
        start_x();
        chk(tx_empty, "R4 start sets empty", {15'd0, tx_empty}, 16'd1);
      end else begin
        cyc(0, 1, 3'h5, lb, 1, 0, 16'h0, rb);
        chk(tx_word == {hb, lb}, "R3 commit with start", tx_word, {hb, lb});
        chk(!tx_empty, "R4 commit beats start", {15'd0, tx_empty}, 16'd0);
        start_x();
        chk(tx_empty, "R4 start after commit", {15'd0, tx_empty}, 16'd1);
      end
      prev = {hb, lb};
    end

    // receive sweep, no parked word
    for (int k = 0; k < 8; k++) begin
      logic [15:0] w;
      w = 16'((k * 16'h1357 + 16'h0A0B) & 16'hFFFF);
      done_w(w);
      chk(rx_full, "R5 done sets full", {15'd0, rx_full}, 16'd1);
      peek(v);
      chk(v == w, "R12 visible word", v, w);
      chk(rx_full, "R13 lo read without status", {15'd0, rx_full}, 16'd1);
      rd_b(3'h3, s);
      chk(s[7] == 1'b1, "R12 status full bit", {8'h0, s}, 16'h0080);
      rd_b(3'h5, s);
      chk(!rx_full, "R7 service clears full", {15'd0, rx_full}, 16'd0);
    end

    // parked word promoted (R6, R8)
    done_w(16'hA1A1);
    done_w(16'hB2B2);
    peek(v);
    chk(v == 16'hA1A1, "R6 visible kept", v, 16'hA1A1);
    service();
    chk(rx_full, "R8 full stays after promote", {15'd0, rx_full}, 16'd1);
    peek(v);
    chk(v == 16'hB2B2, "R8 promoted word", v, 16'hB2B2);
    chk(rx_full, "R8 rearm needed", {15'd0, rx_full}, 16'd1);
    service();
    chk(!rx_full, "R8 second service clears", {15'd0, rx_full}, 16'd0);

    // parked word discarded by start (R9)
    done_w(16'hC3C3);
    done_w(16'hD4D4);
    start_x();
    service();
    chk(!rx_full, "R9 discard then clear", {15'd0, rx_full}, 16'd0);
    peek(v);
    chk(v == 16'hC3C3, "R9 visible unchanged", v, 16'hC3C3);

    // service and start in one cycle (R10)
    done_w(16'hE5E5);
    done_w(16'hF6F6);
    rd_b(3'h3, s);
    cyc(1, 0, 3'h5, 8'h00, 1, 0, 16'h0, rb);
    chk(!rx_full, "R10 start wins", {15'd0, rx_full}, 16'd0);
    peek(v);
    chk(v == 16'hE5E5, "R10 parked dropped", v, 16'hE5E5);

    // service and completion in one cycle, no parked word (R11)
    done_w(16'h1111);
    rd_b(3'h3, s);
    cyc(1, 0, 3'h5, 8'h00, 0, 1, 16'h2222, rb);
    chk(rx_full, "R11 full after combined", {15'd0, rx_full}, 16'd1);
    peek(v);
    chk(v == 16'h2222, "R11 new word visible", v, 16'h2222);
    service();
    chk(!rx_full, "R11 clears afterwards", {15'd0, rx_full}, 16'd0);

    // service and completion in one cycle, word parked (R11)
    done_w(16'h3333);
    done_w(16'h4444);
    rd_b(3'h3, s);
    cyc(1, 0, 3'h5, 8'h00, 0, 1, 16'h5555, rb);
    peek(v);
    chk(v == 16'h4444, "R11 parked promoted", v, 16'h4444);
    service();
    peek(v);
    chk(v == 16'h5555 && rx_full, "R11 new word parked", v, 16'h5555);
    service();
    chk(!rx_full, "R11 final clear", {15'd0, rx_full}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule